// File: doc/BRIEF.md
# Nibble-to-UTOPIA Cell Converter with Tag Stripping

This block accepts framed cells arriving four bits at a time and sends each good one out as a standard 53-byte ATM cell on an 8-bit UTOPIA Level 1 cell-mode transmit port. Each incoming frame may carry a routing tag of zero to four bytes. The tag sits either in front of the header or behind the payload, and the block discards it. Frames that arrive without a HEC byte can have a 0x00 placeholder inserted after the four header bytes, so that the outgoing cell has the standard layout again.

Frames are buffered whole before they are sent. A frame whose length does not match the configuration is discarded, and so is a frame that finds no free cell slot when it starts. Either case sets a sticky error output. On the transmit side the block drives the enable, the start-of-cell marker and odd parity. It starts a cell only when the PHY reports that it can take one. Both sides run on a single clock. The configuration inputs are treated as static while frames are in flight.

Top module: `nib_utopia_cellconv`

## Requirements
- R1: While reset is active and after it is released with no traffic, `tx_enb_n` is 1, `tx_soc` is 0, `tx_data` is 0x00, `tx_prty` is 1 and `frame_err` is 0.
- R2: With `cfg_tag_at_end`=0 and a tag length T, the first T bytes of each frame are dropped. The frame then carries 53+T bytes (52+T when a placeholder is added).
- R3: With `cfg_tag_at_end`=1, the last T bytes of each frame are dropped, and the header and payload are taken from the leading bytes.
- R4: A `cfg_tag_len` value above 4 behaves as 4. A value of 0 passes the frame through unchanged.
- R5: With `cfg_add_hec`=1, the incoming frame is one byte shorter, and output byte index 4 is 0x00 with the remaining bytes shifted up by one.
- R6: Each byte arrives as two nibbles, high nibble first. `nib_sof` is high, with `nib_vld`, on the high nibble of byte 0.
- R7: On every cycle with `tx_enb_n` low, `tx_prty` makes the nine bits {`tx_data`,`tx_prty`} odd parity. The parity bit is driven in the same cycle as the data.
- R8: A cell starts only on the edge after a cycle in which `tx_clav` is high and at least one complete cell is buffered. It then runs for 53 consecutive cycles with `tx_enb_n` low, whatever `tx_clav` does. `tx_soc` is high only with byte 0.
- R9: A frame whose nibble count differs from twice the configured length is discarded, and `frame_err` goes high and stays high until reset.
- R10: The buffer holds SLOTS cells, counting a cell until its last byte has been sent. A frame that starts when every slot is taken (a cell completing on that same edge counts as taken) is discarded and sets `frame_err`.
- R11: A frame ends on the first cycle in which `nib_vld` is low or a new `nib_sof` arrives. Frames may follow each other with no idle cycle, and buffered cells go out back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_tag_len | input | 3 | Number of tag bytes to discard (values above 4 treated as 4) |
| cfg_tag_at_end | input | 1 | 0: tag leads the frame, 1: tag trails the frame |
| cfg_add_hec | input | 1 | 1: insert a 0x00 byte at output index 4 |
| nib_vld | input | 1 | Nibble bus carries data this cycle |
| nib_sof | input | 1 | First nibble of a frame |
| nib_data | input | 4 | Nibble data, high nibble of each byte first |
| tx_clav | input | 1 | PHY can accept a cell |
| tx_enb_n | output | 1 | Active-low transmit enable |
| tx_soc | output | 1 | Start of cell, with byte 0 |
| tx_data | output | 8 | Transmit byte |
| tx_prty | output | 1 | Odd parity over tx_data |
| frame_err | output | 1 | Sticky: a frame was discarded |

## Verification
The hardest case to reach from the ports is a frame that starts on the same edge that the previous frame completes, while the buffer is one slot short of full and the transmitter is stalled. Whether the frame is accepted then depends on how the room check counts the cell that is committing. The stimulus reaches this case by holding `tx_clav` low and sending frames with and without idle gaps, so that the third frame finds both slots taken. It then opens `tx_clav` and confirms that exactly the two older cells leave. Other runs drop `tx_clav` one cycle into a cell to show that the cell is not cut short. Runs with short and long frames show the sticky discard.

// File: rtl/cellconv_pkg.sv
package cellconv_pkg;
  localparam int CELL_BYTES = 53;
  localparam int HDR_BYTES  = 4;
  localparam int MAX_TAG    = 4;
  localparam int IDX_W      = 6;
  localparam int CNT_W      = 8;

  typedef struct packed {
    logic [2:0] tag_len;
    logic       tag_at_end;
    logic       add_hec;
  } cfg_t;

  function automatic logic [2:0] clamp_tag(input logic [2:0] t);
    return (t > 3'(MAX_TAG)) ? 3'(MAX_TAG) : t;
  endfunction
endpackage

// File: rtl/cc_nib_assembler.sv
module cc_nib_assembler
  import cellconv_pkg::*;
#(
  parameter int SLOT_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_t              cfg_i,
  input  logic              nib_vld_i,
  input  logic              nib_sof_i,
  input  logic [3:0]        nib_data_i,
  input  logic              room_i,
  output logic              wr_en_o,
  output logic [SLOT_W-1:0] wr_slot_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [7:0]        wr_byte_o,
  output logic              commit_o,
  output logic              err_o
);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'((1 << SLOT_W) - 1);

  logic              in_frame_q, in_frame_d;
  logic              ok_q, ok_d;
  logic [CNT_W-1:0]  nib_cnt_q, nib_cnt_d;
  logic [3:0]        hi_q, hi_d;
  logic [SLOT_W-1:0] wr_ptr_q, wr_ptr_d;
  logic              err_q, err_d;

  logic [2:0]        tag;
  logic [6:0]        frame_bytes;
  logic [6:0]        byte_idx;
  logic [6:0]        out_idx;
  logic              frame_end, len_ok, start, cont, keep, drop;

  always_comb begin
    tag         = clamp_tag(cfg_i.tag_len);
    frame_bytes = 7'(CELL_BYTES) + 7'(tag) - 7'(cfg_i.add_hec);
    frame_end   = in_frame_q && (!nib_vld_i || nib_sof_i);
    len_ok      = (nib_cnt_q == {frame_bytes, 1'b0});
    commit_o    = frame_end && ok_q && len_ok;
    drop        = frame_end && !(ok_q && len_ok);
    start       = nib_vld_i && nib_sof_i;
    cont        = nib_vld_i && !nib_sof_i && in_frame_q;
    byte_idx    = nib_cnt_q[7:1];
    if (cfg_i.tag_at_end) begin
      keep    = byte_idx < (frame_bytes - 7'(tag));
      out_idx = byte_idx;
    end else begin
      keep    = (byte_idx >= 7'(tag)) && (byte_idx < frame_bytes);
      out_idx = byte_idx - 7'(tag);
    end
    wr_en_o   = cont && nib_cnt_q[0] && ok_q && keep;
    wr_idx_o  = out_idx[IDX_W-1:0];
    wr_byte_o = {hi_q, nib_data_i};
    wr_slot_o = wr_ptr_q;
    err_o     = err_q;
  end

  always_comb begin
    in_frame_d = in_frame_q;
    ok_d       = ok_q;
    nib_cnt_d  = nib_cnt_q;
    hi_d       = hi_q;
    wr_ptr_d   = wr_ptr_q;
    err_d      = err_q | drop;
    if (start) begin
      in_frame_d = 1'b1;
      ok_d       = room_i;
      nib_cnt_d  = 8'd1;
      hi_d       = nib_data_i;
    end else if (cont) begin
      if (nib_cnt_q != '1) nib_cnt_d = nib_cnt_q + 8'd1;
      if (!nib_cnt_q[0]) hi_d = nib_data_i;
    end else begin
      in_frame_d = 1'b0;
    end
    if (commit_o) wr_ptr_d = (wr_ptr_q == SLOT_LAST) ? '0 : wr_ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      ok_q       <= 1'b0;
      nib_cnt_q  <= '0;
      hi_q       <= '0;
      wr_ptr_q   <= '0;
      err_q      <= 1'b0;
    end else begin
      in_frame_q <= in_frame_d;
      ok_q       <= ok_d;
      nib_cnt_q  <= nib_cnt_d;
      hi_q       <= hi_d;
      wr_ptr_q   <= wr_ptr_d;
      err_q      <= err_d;
    end
  end

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R11
  commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> (!nib_vld_i || nib_sof_i));
endmodule

// File: rtl/cc_cell_store.sv
module cc_cell_store
  import cellconv_pkg::*;
#(
  parameter int SLOTS  = 2,
  parameter int SLOT_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              add_hec_i,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [7:0]        wr_byte_i,
  input  logic              commit_i,
  input  logic              release_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [7:0]        rd_byte_o,
  output logic              avail_o,
  output logic              room_o
);
  localparam int OCC_W = $clog2(SLOTS + 1);
  localparam logic [SLOT_W-1:0] PTR_LAST = SLOT_W'(SLOTS - 1);

  logic [7:0]        mem_q [SLOTS][CELL_BYTES];
  logic [OCC_W-1:0]  cnt_q, cnt_d;
  logic [SLOT_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [IDX_W-1:0]  src_idx;

  genvar s;
  generate
    for (s = 0; s < SLOTS; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (wr_en_i && (wr_slot_i == SLOT_W'(s))) mem_q[s][wr_idx_i] <= wr_byte_i;
      end
    end
  endgenerate

  always_comb begin
    src_idx = (add_hec_i && (rd_idx_i > IDX_W'(HDR_BYTES))) ? rd_idx_i - 1'b1 : rd_idx_i;
    if (add_hec_i && (rd_idx_i == IDX_W'(HDR_BYTES))) rd_byte_o = 8'h00;
    else                                              rd_byte_o = mem_q[rd_ptr_q][src_idx];
    avail_o  = (cnt_q != '0);
    room_o   = ((OCC_W+1)'(cnt_q) + (OCC_W+1)'(commit_i)) < (OCC_W+1)'(SLOTS);
    cnt_d    = cnt_q + OCC_W'(commit_i) - OCC_W'(release_i);
    rd_ptr_d = rd_ptr_q;
    if (release_i) rd_ptr_d = (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      rd_ptr_q <= '0;
    end else begin
      cnt_q    <= cnt_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |-> ((cnt_q < OCC_W'(SLOTS)) || release_i));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |-> (cnt_q != '0));
endmodule

// File: rtl/cc_utopia_tx.sv
module cc_utopia_tx
  import cellconv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_clav_i,
  input  logic             avail_i,
  input  logic [7:0]       rd_byte_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             release_o,
  output logic [7:0]       tx_data_o,
  output logic             tx_soc_o,
  output logic             tx_enb_n_o,
  output logic             tx_prty_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [7:0]       data_q, data_d;
  logic             soc_q, soc_d, enb_n_q, enb_n_d, prty_q, prty_d;
  logic             start, send;

  always_comb begin
    start     = !busy_q && avail_i && tx_clav_i;
    send      = busy_q || start;
    rd_idx_o  = busy_q ? idx_q : '0;
    release_o = busy_q && (idx_q == LAST_IDX);
    busy_d    = start ? 1'b1 : (release_o ? 1'b0 : busy_q);
    idx_d     = start ? IDX_W'(1) : (busy_q ? idx_q + 1'b1 : idx_q);
    data_d    = send ? rd_byte_i : 8'h00;
    soc_d     = start;
    enb_n_d   = !send;
    prty_d    = ~^data_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      data_q  <= 8'h00;
      soc_q   <= 1'b0;
      enb_n_q <= 1'b1;
      prty_q  <= 1'b1;
    end else begin
      busy_q  <= busy_d;
      idx_q   <= idx_d;
      data_q  <= data_d;
      soc_q   <= soc_d;
      enb_n_q <= enb_n_d;
      prty_q  <= prty_d;
    end
  end

  assign tx_data_o  = data_q;
  assign tx_soc_o   = soc_q;
  assign tx_enb_n_o = enb_n_q;
  assign tx_prty_o  = prty_q;

  // R8
  soc_clav_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_soc_o |-> $past(tx_clav_i));

  // R8
  soc_then_enb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_soc_o |=> !tx_enb_n_o);
endmodule

// File: rtl/nib_utopia_cellconv.sv
module nib_utopia_cellconv
  import cellconv_pkg::*;
#(
  parameter int SLOTS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cfg_tag_len,
  input  logic       cfg_tag_at_end,
  input  logic       cfg_add_hec,
  input  logic       nib_vld,
  input  logic       nib_sof,
  input  logic [3:0] nib_data,
  input  logic       tx_clav,
  output logic       tx_enb_n,
  output logic       tx_soc,
  output logic [7:0] tx_data,
  output logic       tx_prty,
  output logic       frame_err
);
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic              rst_meta_q, rst_sync_q;
  cfg_t              cfg;
  logic              wr_en, commit, release_w, avail, room;
  logic [SLOT_W-1:0] wr_slot;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [7:0]        wr_byte, rd_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign cfg = '{tag_len: cfg_tag_len, tag_at_end: cfg_tag_at_end, add_hec: cfg_add_hec};

  cc_nib_assembler #(.SLOT_W(SLOT_W)) i_asm (
    .clk(clk), .rst_n(rst_sync_q), .cfg_i(cfg),
    .nib_vld_i(nib_vld), .nib_sof_i(nib_sof), .nib_data_i(nib_data),
    .room_i(room), .wr_en_o(wr_en), .wr_slot_o(wr_slot), .wr_idx_o(wr_idx),
    .wr_byte_o(wr_byte), .commit_o(commit), .err_o(frame_err)
  );

  cc_cell_store #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) i_store (
    .clk(clk), .rst_n(rst_sync_q), .add_hec_i(cfg_add_hec),
    .wr_en_i(wr_en), .wr_slot_i(wr_slot), .wr_idx_i(wr_idx), .wr_byte_i(wr_byte),
    .commit_i(commit), .release_i(release_w), .rd_idx_i(rd_idx),
    .rd_byte_o(rd_byte), .avail_o(avail), .room_o(room)
  );

  cc_utopia_tx i_tx (
    .clk(clk), .rst_n(rst_sync_q), .tx_clav_i(tx_clav), .avail_i(avail),
    .rd_byte_i(rd_byte), .rd_idx_o(rd_idx), .release_o(release_w),
    .tx_data_o(tx_data), .tx_soc_o(tx_soc), .tx_enb_n_o(tx_enb_n), .tx_prty_o(tx_prty)
  );
endmodule

// File: tb/test_nib_utopia_cellconv.sv
module test_nib_utopia_cellconv;
  localparam int SLOTS = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] cfg_tag_len;
  logic       cfg_tag_at_end, cfg_add_hec;
  logic       nib_vld, nib_sof;
  logic [3:0] nib_data;
  logic       tx_clav;
  logic       tx_enb_n, tx_soc, tx_prty, frame_err;
  logic [7:0] tx_data;

  int n_tests = 0;
  int n_fail  = 0;
  int rtl_cells = 0;
  bit chk_en = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  nib_utopia_cellconv #(.SLOTS(SLOTS)) i_nib_utopia_cellconv (
    .clk(clk), .rst_n(rst_n), .cfg_tag_len(cfg_tag_len), .cfg_tag_at_end(cfg_tag_at_end),
    .cfg_add_hec(cfg_add_hec), .nib_vld(nib_vld), .nib_sof(nib_sof), .nib_data(nib_data),
    .tx_clav(tx_clav), .tx_enb_n(tx_enb_n), .tx_soc(tx_soc), .tx_data(tx_data),
    .tx_prty(tx_prty), .frame_err(frame_err)
  );

  // Behavioural reference model
  int         m_nibs[$];
  logic [7:0] m_pend[$];
  logic [7:0] m_cell[$];
  bit   m_in_frame, m_ok, m_busy, m_commit, m_rel;
  int   m_ncells, m_k, m_tag, m_len;
  logic [7:0] e_data;
  logic e_soc, e_enb_n, e_prty, e_err;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_nibs.delete(); m_pend.delete();
      m_in_frame = 0; m_ok = 0; m_busy = 0; m_ncells = 0; m_k = 0;
      e_data = 8'h00; e_soc = 0; e_enb_n = 1; e_prty = 1; e_err = 0;
    end else begin
      m_tag = (cfg_tag_len > 4) ? 4 : int'(cfg_tag_len);
      m_len = 53 + m_tag - int'(cfg_add_hec);
      m_rel = 0;
      if (m_busy) begin
        e_data = m_pend.pop_front(); e_soc = 0; e_enb_n = 0; m_k++;
        if (m_k == 53) begin m_busy = 0; m_rel = 1; end
      end else if (m_ncells > 0 && tx_clav) begin
        m_busy = 1; m_k = 1;
        e_data = m_pend.pop_front(); e_soc = 1; e_enb_n = 0;
      end else begin
        e_data = 8'h00; e_soc = 0; e_enb_n = 1;
      end
      e_prty = ~^e_data;
      m_commit = 0;
      if (m_in_frame && (!nib_vld || nib_sof)) begin
        if (m_ok && m_nibs.size() == 2 * m_len) begin
          m_cell.delete();
          for (int b = 0; b < m_len; b++) begin
            if (cfg_tag_at_end ? (b < m_len - m_tag) : (b >= m_tag))
              m_cell.push_back(8'((m_nibs[2*b] << 4) | m_nibs[2*b+1]));
          end
          if (cfg_add_hec) m_cell.insert(4, 8'h00);
          foreach (m_cell[i]) m_pend.push_back(m_cell[i]);
          m_commit = 1;
        end else begin
          e_err = 1;
        end
        m_in_frame = 0;
      end
      if (nib_vld && nib_sof) begin
        m_ok = (m_ncells + int'(m_commit)) < SLOTS;
        m_nibs.delete();
        m_nibs.push_back(int'(nib_data));
        m_in_frame = 1;
      end else if (nib_vld && m_in_frame) begin
        m_nibs.push_back(int'(nib_data));
      end
      m_ncells = m_ncells + int'(m_commit) - int'(m_rel);
    end
  end

  // Every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && chk_en) begin
      n_tests++;
      if (tx_data !== e_data || tx_soc !== e_soc || tx_enb_n !== e_enb_n ||
          tx_prty !== e_prty || frame_err !== e_err) begin
        n_fail++;
        $display("FAIL %s t=%0t data/soc/enb_n/prty/err=%h/%b/%b/%b/%b expected %h/%b/%b/%b/%b",
                 cur_req, $time, tx_data, tx_soc, tx_enb_n, tx_prty, frame_err,
                 e_data, e_soc, e_enb_n, e_prty, e_err);
      end
      if (!tx_enb_n) begin
        n_tests++;
        // R7 odd parity on each transferred byte
        if ((^{tx_data, tx_prty}) !== 1'b1) begin
          n_fail++;
          $display("FAIL R7 parity data=%h prty=%b expected odd total", tx_data, tx_prty);
        end
      end
      if (tx_soc === 1'b1) rtl_cells++;
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk); nib_vld = 0; nib_sof = 0; nib_data = 4'h0;
    end
  endtask

  task automatic send_frame(input int nbytes, input bit gap);
    for (int i = 0; i < nbytes; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      @(negedge clk); nib_vld = 1; nib_sof = (i == 0); nib_data = b[7:4];
      @(negedge clk); nib_vld = 1; nib_sof = 0;       nib_data = b[3:0];
    end
    if (gap) idle(1);
  endtask

  task automatic set_cfg(input int t, input bit at_end, input bit hec);
    @(negedge clk);
    cfg_tag_len = 3'(t); cfg_tag_at_end = at_end; cfg_add_hec = hec;
  endtask

  task automatic expect_cells(input int base, input int n, input string req);
    n_tests++;
    if (rtl_cells - base != n) begin
      n_fail++;
      $display("FAIL %s cells sent=%0d expected %0d", req, rtl_cells - base, n);
    end
  endtask

  task automatic expect_err(input bit v, input string req);
    @(negedge clk);
    n_tests++;
    if (frame_err !== v) begin
      n_fail++;
      $display("FAIL %s frame_err=%b expected %b", req, frame_err, v);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; nib_vld = 0; nib_sof = 0; nib_data = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      n_tests++;
      // R1 reset values at the ports
      if (tx_enb_n !== 1'b1 || tx_soc !== 1'b0 || tx_data !== 8'h00 ||
          tx_prty !== 1'b1 || frame_err !== 1'b0) begin
        n_fail++;
        $display("FAIL R1 enb_n/soc/data/prty/err=%b/%b/%h/%b/%b expected 1/0/00/1/0",
                 tx_enb_n, tx_soc, tx_data, tx_prty, frame_err);
      end
    end
    rst_n = 1;
    idle(4);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired in %s", cur_req);
    summary();
    $finish;
  end

  initial begin
    int base;
    rst_n = 0; cfg_tag_len = 0; cfg_tag_at_end = 0; cfg_add_hec = 0;
    nib_vld = 0; nib_sof = 0; nib_data = 0; tx_clav = 1;
    do_reset();
    chk_en = 1;
    idle(5);

    cur_req = "R6"; base = rtl_cells;
    set_cfg(0, 0, 0);
    send_frame(53, 1); send_frame(53, 1); idle(150);
    expect_cells(base, 2, "R6");

    cur_req = "R2"; base = rtl_cells;
    set_cfg(2, 0, 0);
    send_frame(55, 1); send_frame(55, 1); idle(150);
    expect_cells(base, 2, "R2");

    cur_req = "R3"; base = rtl_cells;
    set_cfg(3, 1, 0);
    send_frame(56, 1); send_frame(56, 1); idle(150);
    expect_cells(base, 2, "R3");

    cur_req = "R4"; base = rtl_cells;
    set_cfg(6, 0, 1);
    send_frame(56, 1); idle(100);
    set_cfg(7, 1, 0);
    send_frame(57, 1); idle(100);
    expect_cells(base, 2, "R4");

    cur_req = "R5"; base = rtl_cells;
    set_cfg(0, 0, 1);
    send_frame(52, 1); send_frame(52, 1);
    set_cfg(2, 1, 1);
    send_frame(54, 1); idle(200);
    expect_cells(base, 3, "R5");

    cur_req = "R11"; base = rtl_cells;
    set_cfg(1, 1, 0);
    send_frame(54, 0); send_frame(54, 0); send_frame(54, 1); idle(200);
    expect_cells(base, 3, "R11");
    expect_err(1'b0, "R11");

    cur_req = "R8"; base = rtl_cells;
    set_cfg(0, 0, 0);
    tx_clav = 0;
    send_frame(53, 1); idle(30);
    expect_cells(base, 0, "R8");
    @(negedge clk); tx_clav = 1;
    @(negedge clk); tx_clav = 0;
    idle(80);
    expect_cells(base, 1, "R8");
    tx_clav = 1;

    cur_req = "R9"; base = rtl_cells;
    set_cfg(0, 0, 0);
    send_frame(50, 1); idle(3);
    expect_err(1'b1, "R9");
    send_frame(55, 1); send_frame(53, 1); idle(150);
    expect_cells(base, 1, "R9");
    expect_err(1'b1, "R9");

    cur_req = "R10";
    do_reset();
    base = rtl_cells;
    set_cfg(0, 0, 0);
    tx_clav = 0;
    send_frame(53, 0); send_frame(53, 1); idle(3);
    expect_err(1'b0, "R10");
    send_frame(53, 1); idle(3);
    expect_err(1'b1, "R10");
    expect_cells(base, 0, "R10");
    tx_clav = 1;
    idle(200);
    expect_cells(base, 2, "R10");

    idle(5);
    summary();
    $finish;
  end
endmodule